// File: doc/BRIEF.md
# Segment Line Buffer with Valid-State Counter

This block sits at the end of one line segment of a pixel matrix and collects the encoded state words that pixels place on the shared line bus while a token travels along the segment. It holds a chain of entries. On each capture strobe (the token clock), the word on the bus enters the first entry and every older word moves one place further down the chain. A small counter tracks how many of the captured words were valid states. The counter only advances while the token injected into the segment is still out.

For readout, the same registers become scan flip-flops. While scan is enabled, every entry and the counter load the matching entry and counter of the neighbouring line's buffer in a single cycle. Buffers stacked line over line therefore move as one column toward the readout end. Because the counter travels with the data, the reader knows how many entries of each line hold real states. The counter clears at the start of every frame.

Top module: `seg_line_buf`

## Requirements
- R1: After reset is asserted (rst_n low), every entry of `scan_out_data` and `scan_out_cnt` reads zero.
- R2: In a cycle with `cap_stb`=1, `scan_en`=0 and `frame_start`=0, entry 0 (bits [9:0]) takes `bus_word`. Each entry i (bits [10i+9:10i]) takes the previous value of entry i-1. Both are visible after that clock edge.
- R3: A capture cycle raises the count by one only when `bus_valid`=1 and `tok_back`=0. Otherwise the count is unchanged, although the data still shifts.
- R4: The count saturates at DEPTH (8). Further valid captures leave it at 8.
- R5: `frame_start`=1 with `scan_en`=0 clears the count to 0. It leaves all entries unchanged, even if `cap_stb` is also 1.
- R6: In a cycle with `scan_en`=1, every entry loads the matching slice of `scan_in_data` and the count loads `scan_in_cnt`.
- R7: `scan_en` takes priority over `cap_stb` and `frame_start`. With all three high, the result is exactly the scan load of R6.
- R8: With `scan_en`, `frame_start` and `cap_stb` all low, entries and count hold their values whatever `bus_word`, `bus_valid` and `tok_back` do.
- R9: After DEPTH consecutive captures, entry 0 holds the newest word and entry DEPTH-1 holds the oldest of the last DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Clears the valid-state count |
| cap_stb | input | 1 | Token-clock capture strobe |
| bus_word | input | 10 | State word from the line bus |
| bus_valid | input | 1 | Bus carries a valid state this strobe |
| tok_back | input | 1 | Token has returned to the segment end |
| scan_en | input | 1 | Vertical scan shift enable |
| scan_in_data | input | 80 | Entries of the neighbouring line buffer |
| scan_in_cnt | input | 4 | Count of the neighbouring line buffer |
| scan_out_data | output | 80 | Entries of this buffer, entry i at [10i+9:10i] |
| scan_out_cnt | output | 4 | Valid-state count of this buffer |

## Verification
A corrupted entry shows up on `scan_out_data` one clock after the faulty write. It then moves one slice per capture, so a misordered shift turns into a visible word swap within DEPTH strobes. A wrong count appears on `scan_out_cnt` in the cycle after the bad increment or clear. In the chain it would misreport the valid depth of its line. A broken priority between scan and capture appears after a single cycle as a mix of bus and scan-in data.

// File: rtl/seg_buf_pkg.sv
package seg_buf_pkg;
  localparam int unsigned SEG_DATA_W = 10;
  localparam int unsigned SEG_DEPTH  = 8;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CAPT  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_SCAN  = 2'd3
  } seg_op_e;
endpackage

// File: rtl/seg_buf_entry.sv
module seg_buf_entry #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_sel,
  input  logic              shift_sel,
  input  logic [DATA_W-1:0] scan_d,
  input  logic [DATA_W-1:0] shift_d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (scan_sel)       q_nxt = scan_d;
    else if (shift_sel) q_nxt = shift_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/seg_hit_counter.sv
module seg_hit_counter #(
  parameter int unsigned LIMIT = 8,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(LIMIT);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (load)                      cnt_nxt = load_val;
    else if (clear)                cnt_nxt = '0;
    else if (inc && (cnt != MAXV)) cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/seg_line_buf.sv
module seg_line_buf
  import seg_buf_pkg::*;
#(
  parameter int unsigned DATA_W = SEG_DATA_W,
  parameter int unsigned DEPTH  = SEG_DEPTH
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          cap_stb,
  input  logic [DATA_W-1:0]             bus_word,
  input  logic                          bus_valid,
  input  logic                          tok_back,
  input  logic                          scan_en,
  input  logic [DEPTH*DATA_W-1:0]       scan_in_data,
  input  logic [$clog2(DEPTH+1)-1:0]    scan_in_cnt,
  output logic [DEPTH*DATA_W-1:0]       scan_out_data,
  output logic [$clog2(DEPTH+1)-1:0]    scan_out_cnt
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  seg_op_e op;

  // Scan wins, then frame clear, then token-clock capture.
  always_comb begin
    if (scan_en)          op = OP_SCAN;
    else if (frame_start) op = OP_CLEAR;
    else if (cap_stb)     op = OP_CAPT;
    else                  op = OP_HOLD;
  end

  logic do_scan, do_shift, do_clear, do_inc;
  assign do_scan  = (op == OP_SCAN);
  assign do_shift = (op == OP_CAPT);
  assign do_clear = (op == OP_CLEAR);
  assign do_inc   = do_shift && bus_valid && !tok_back;

  logic [DATA_W-1:0] q [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic [DATA_W-1:0] feed;
      if (gi == 0) begin : g_head
        assign feed = bus_word;
      end else begin : g_body
        assign feed = q[gi-1];
      end
      seg_buf_entry #(.DATA_W(DATA_W)) u_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_sel (do_scan),
        .shift_sel(do_shift),
        .scan_d   (scan_in_data[gi*DATA_W +: DATA_W]),
        .shift_d  (feed),
        .q        (q[gi])
      );
      assign scan_out_data[gi*DATA_W +: DATA_W] = q[gi];
    end
  endgenerate

  seg_hit_counter #(.LIMIT(DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (do_scan),
    .load_val(scan_in_cnt),
    .clear   (do_clear),
    .inc     (do_inc),
    .cnt     (scan_out_cnt)
  );
endmodule

// File: rtl/seg_line_buf_chk.sv
module seg_line_buf_chk #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       frame_start,
  input logic                       cap_stb,
  input logic [DATA_W-1:0]          bus_word,
  input logic                       bus_valid,
  input logic                       tok_back,
  input logic                       scan_en,
  input logic [DEPTH*DATA_W-1:0]    scan_in_data,
  input logic [$clog2(DEPTH+1)-1:0] scan_in_cnt,
  input logic [DEPTH*DATA_W-1:0]    scan_out_data,
  input logic [$clog2(DEPTH+1)-1:0] scan_out_cnt
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(DEPTH);

  logic capt;
  assign capt = cap_stb && !scan_en && !frame_start;

  p_capture_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capt |=> scan_out_data[DATA_W-1:0] == $past(bus_word));

  p_capture_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capt |=> scan_out_data[DEPTH*DATA_W-1:DATA_W] ==
             $past(scan_out_data[(DEPTH-1)*DATA_W-1:0]));

  p_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (capt && (!bus_valid || tok_back)) |=> $stable(scan_out_cnt));

  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !frame_start && scan_out_cnt == MAXV) |=> scan_out_cnt == MAXV);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !scan_en) |=> (scan_out_cnt == '0) && $stable(scan_out_data));

  p_scan_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (scan_out_data == $past(scan_in_data)) &&
                (scan_out_cnt == $past(scan_in_cnt)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !frame_start && !cap_stb) |=>
      $stable(scan_out_data) && $stable(scan_out_cnt));
endmodule

bind seg_line_buf seg_line_buf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start  (frame_start),
  .cap_stb      (cap_stb),
  .bus_word     (bus_word),
  .bus_valid    (bus_valid),
  .tok_back     (tok_back),
  .scan_en      (scan_en),
  .scan_in_data (scan_in_data),
  .scan_in_cnt  (scan_in_cnt),
  .scan_out_data(scan_out_data),
  .scan_out_cnt (scan_out_cnt)
);

// File: tb/seg_line_buf_bench.sv
module seg_line_buf_bench;
  localparam int W = 10;
  localparam int D = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_start, cap_stb, bus_valid, tok_back, scan_en;
  logic [W-1:0] bus_word;
  logic [D*W-1:0] scan_in_data, scan_out_data;
  logic [CW-1:0] scan_in_cnt, scan_out_cnt;

  always #4 clk = ~clk;

  seg_line_buf u_seg_line_buf (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cap_stb(cap_stb),
    .bus_word(bus_word), .bus_valid(bus_valid), .tok_back(tok_back),
    .scan_en(scan_en), .scan_in_data(scan_in_data), .scan_in_cnt(scan_in_cnt),
    .scan_out_data(scan_out_data), .scan_out_cnt(scan_out_cnt)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] model [D];

  // {cap, valid, back, fs, word[9:0], expected count[3:0]}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {4'b1100, 10'h101, 4'd1},  // R2 R3
    {4'b1100, 10'h202, 4'd2},  // R3
    {4'b1000, 10'h303, 4'd2},  // R3 invalid word
    {4'b0100, 10'h3FF, 4'd2},  // R8 no strobe
    {4'b1100, 10'h004, 4'd3},
    {4'b1110, 10'h005, 4'd3},  // R3 token back
    {4'b0001, 10'h0AA, 4'd0},  // R5 clear
    {4'b1100, 10'h011, 4'd1},
    {4'b1100, 10'h012, 4'd2},
    {4'b1100, 10'h013, 4'd3},
    {4'b1100, 10'h014, 4'd4},
    {4'b1100, 10'h015, 4'd5},
    {4'b1100, 10'h016, 4'd6},
    {4'b1100, 10'h017, 4'd7},
    {4'b1100, 10'h018, 4'd8},
    {4'b1100, 10'h019, 4'd8},  // R4 saturation
    {4'b1101, 10'h1E1, 4'd0}   // R5 clear beats capture
  };

  task automatic check_data(input string req);
    for (int i = 0; i < D; i++) begin
      n_chk++;
      if (scan_out_data[i*W +: W] !== model[i]) begin
        n_bad++;
        $display("FAIL %s entry %0d actual %h expected %h", req, i,
                 scan_out_data[i*W +: W], model[i]);
      end
    end
  endtask

  task automatic check_cnt(input string req, input logic [CW-1:0] exp);
    n_chk++;
    if (scan_out_cnt !== exp) begin
      n_bad++;
      $display("FAIL %s count actual %0d expected %0d", req, scan_out_cnt, exp);
    end
  endtask

  task automatic idle();
    frame_start = 0; cap_stb = 0; bus_valid = 0; tok_back = 0; scan_en = 0;
    bus_word = '0; scan_in_data = '0; scan_in_cnt = '0;
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    for (int i = 0; i < D; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    #1;
    check_data("R1"); check_cnt("R1", 4'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      idle();
      cap_stb = VEC[v][17]; bus_valid = VEC[v][16];
      tok_back = VEC[v][15]; frame_start = VEC[v][14];
      bus_word = VEC[v][13:4];
      scan_in_data = {D{10'h3C3}}; scan_in_cnt = 4'd7;  // must be ignored
      @(posedge clk);
      if (VEC[v][17] && !VEC[v][14]) begin
        for (int i = D - 1; i > 0; i--) model[i] = model[i-1];
        model[0] = VEC[v][13:4];
      end
      #1;
      check_data("R2/R5/R8 data");
      check_cnt("R3/R4/R5 count", VEC[v][3:0]);
    end

    // R9: oldest of the last eight words at the far end, newest at the head
    n_chk++;
    if (scan_out_data[W-1:0] !== 10'h019 || scan_out_data[D*W-1 -: W] !== 10'h012) begin
      n_bad++;
      $display("FAIL R9 head/tail actual %h/%h expected 019/012",
               scan_out_data[W-1:0], scan_out_data[D*W-1 -: W]);
    end

    // R6: plain scan load
    @(negedge clk);
    idle();
    scan_en = 1;
    for (int i = 0; i < D; i++) scan_in_data[i*W +: W] = W'(10'h040 + i * 3);
    scan_in_cnt = 4'd5;
    @(posedge clk);
    for (int i = 0; i < D; i++) model[i] = W'(10'h040 + i * 3);
    #1;
    check_data("R6"); check_cnt("R6", 4'd5);

    // R7: scan beats capture and frame clear
    @(negedge clk);
    scan_en = 1; cap_stb = 1; frame_start = 1; bus_valid = 1; bus_word = 10'h2F0;
    for (int i = 0; i < D; i++) scan_in_data[i*W +: W] = W'(10'h300 - i * 7);
    scan_in_cnt = 4'd3;
    @(posedge clk);
    for (int i = 0; i < D; i++) model[i] = W'(10'h300 - i * 7);
    #1;
    check_data("R7"); check_cnt("R7", 4'd3);

    // R8: idle with busy bus inputs
    @(negedge clk);
    idle();
    bus_valid = 1; bus_word = 10'h155; tok_back = 1;
    repeat (3) @(posedge clk);
    #1;
    check_data("R8"); check_cnt("R8", 4'd3);

    // R1: reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    #2;
    for (int i = 0; i < D; i++) model[i] = '0;
    check_data("R1 mid"); check_cnt("R1 mid", 4'd0);
    @(negedge clk) rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule